// File: doc/BRIEF.md
# Interrupt Request and Service Tracker

This block holds the per-vector bookkeeping for an interrupt controller. It has one bit for each of 256 vector numbers in four bit vectors: requested, in service, enabled, and trigger mode. A source posts a vector with a raise command. A source withdraws a vector with a lower command. The consumer takes a vector with an acknowledge command, which moves the vector from requested to in service. Each command carries an 8-bit vector number and has its own valid strobe, so all three commands can occur in the same cycle.

The block shows whether any vector is requested and which requested vector has the highest number. Software reads all four vectors through a 32-bit word port. Software can write only the enable vector through that port. Writes to the other vectors are refused and the block flags them. A raise for a vector number below 16 is illegal. The block refuses it and flags it. A raise for a vector whose enable bit is clear is dropped without any flag.

Top module: `vec_tracker`

## Requirements
- R1: After reset, every enable bit is 1 and every request, in-service and trigger bit is 0. The outputs pending, top_vec, raise_err and reg_wr_err are all 0.
- R2: A raise for vector v with v >= 16 and enable bit v equal to 1 sets request bit v at the next clock edge.
- R3: A raise for a vector below 16 drives raise_err high for exactly the cycle after the command. It changes no request, in-service or enable bit.
- R4: A raise for a vector whose enable bit is 0 changes no state and does not assert raise_err.
- R5: A lower command for vector v clears request bit v and leaves every other bit unchanged.
- R6: An acknowledge for vector v sets in-service bit v and clears request bit v at the same clock edge. In-service bits are never cleared except by reset.
- R7: pending is 1 whenever any request bit is set. top_vec is the highest-numbered set request bit, or 0 when none is set. Both follow the stored request bits combinationally, so they are valid in the cycle after the edge that changed those bits, and they stay stable while no command is issued.
- R8: When an accepted raise and an acknowledge or a lower name the same vector in the same cycle, the raise wins and the request bit ends up set. The in-service bit is still set by the acknowledge.
- R9: A read returns a combinational 32-bit word, selected by reg_addr, in which bit j of word k is vector 32k+j, for k from 0 to 7. The in-service words are at 0x100+0x10k, the trigger words at 0x180+0x10k, the request words at 0x200+0x10k and the enable words at 0x480+0x10k. Any other address reads 0.
- R10: A write to an enable word replaces those 32 enable bits at the clock edge. A raise in the same cycle is judged against the old enable value.
- R11: A write to an in-service, trigger or request word changes no state and drives reg_wr_err high for exactly the next cycle. A write to an unmapped address changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Raise command strobe |
| raise_vec | input | 8 | Vector number to raise |
| lower_valid | input | 1 | Lower command strobe |
| lower_vec | input | 8 | Vector number to lower |
| ack_valid | input | 1 | Acknowledge command strobe |
| ack_vec | input | 8 | Vector number being acknowledged |
| reg_addr | input | 12 | Byte offset of the register word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| reg_wr_err | output | 1 | Pulse one cycle after a write to a read-only word |
| raise_err | output | 1 | Pulse one cycle after an illegal raise |
| pending | output | 1 | Any request bit set |
| top_vec | output | 8 | Highest-numbered requested vector |

## Verification
All stored state changes at the clock edge that samples a command or a write. pending, top_vec and reg_rdata depend only on stored state and reg_addr, so they show the result in the first cycle after that edge. raise_err and reg_wr_err are registered, so they pulse in that same cycle and clear one cycle later. The bench drives inputs on the falling edge and steps a behavioural model at the rising edge. On the next falling edge it compares every output with the model, so each check reads a result exactly one edge after its stimulus.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int ADDR_W    = 12;
  localparam int WORD_STEP = 16;

  localparam logic [ADDR_W-1:0] BASE_ISR  = 12'h100;
  localparam logic [ADDR_W-1:0] BASE_TRIG = 12'h180;
  localparam logic [ADDR_W-1:0] BASE_REQ  = 12'h200;
  localparam logic [ADDR_W-1:0] BASE_EN   = 12'h480;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ISR,
    RGN_TRIG,
    RGN_REQ,
    RGN_EN
  } vt_region_e;

  // True when addr lands on a word-aligned slot inside a region of nwords words
  function automatic logic in_region(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int nwords);
    int unsigned a, b;
    a = int'(addr);
    b = int'(base);
    return (a >= b) && (a < b + nwords * WORD_STEP) && (addr[3:0] == 4'h0);
  endfunction

  function automatic vt_region_e decode_region(input logic [ADDR_W-1:0] addr,
                                               input int nwords);
    if (in_region(addr, BASE_ISR, nwords))  return RGN_ISR;
    if (in_region(addr, BASE_TRIG, nwords)) return RGN_TRIG;
    if (in_region(addr, BASE_REQ, nwords))  return RGN_REQ;
    if (in_region(addr, BASE_EN, nwords))   return RGN_EN;
    return RGN_NONE;
  endfunction

  // Word index inside a region (meaningful only after decode_region hit)
  function automatic int word_index(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] base);
    return (int'(addr) - int'(base)) / WORD_STEP;
  endfunction
endpackage

// File: rtl/vt_vec_bank.sv
module vt_vec_bank #(
  parameter int NUM_VEC   = 256,
  parameter int WORD_W    = 32,
  parameter int MIN_LEGAL = 16,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_valid,
  input  logic [VEC_W-1:0]   raise_vec,
  input  logic               lower_valid,
  input  logic [VEC_W-1:0]   lower_vec,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vec,
  input  logic               en_wr,
  input  logic [WIDX_W-1:0]  en_wr_word,
  input  logic [WORD_W-1:0]  en_wr_data,
  output logic [NUM_VEC-1:0] req_vec,
  output logic [NUM_VEC-1:0] isr_vec,
  output logic [NUM_VEC-1:0] en_vec,
  output logic               raise_accept,
  output logic               raise_illegal,
  output logic               raise_err
);
  logic [NUM_VEC-1:0] req_nxt, isr_nxt, en_nxt;

  assign raise_illegal = raise_valid && (int'(raise_vec) < MIN_LEGAL);
  assign raise_accept  = raise_valid && !raise_illegal && en_vec[raise_vec];

  always_comb begin
    req_nxt = req_vec;
    isr_nxt = isr_vec;
    if (lower_valid) req_nxt[lower_vec] = 1'b0;
    if (ack_valid) begin
      isr_nxt[ack_vec] = 1'b1;
      req_nxt[ack_vec] = 1'b0;
    end
    if (raise_accept) req_nxt[raise_vec] = 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < NUM_WORDS; k++) begin : g_en_word
      always_comb begin
        if (en_wr && (int'(en_wr_word) == k))
          en_nxt[k*WORD_W +: WORD_W] = en_wr_data;
        else
          en_nxt[k*WORD_W +: WORD_W] = en_vec[k*WORD_W +: WORD_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_vec   <= '0;
      isr_vec   <= '0;
      en_vec    <= '1;
      raise_err <= 1'b0;
    end else begin
      req_vec   <= req_nxt;
      isr_vec   <= isr_nxt;
      en_vec    <= en_nxt;
      raise_err <= raise_illegal;
    end
  end
endmodule

// File: rtl/vt_prio_enc.sv
module vt_prio_enc #(
  parameter int NUM_VEC = 256,
  localparam int VEC_W = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req_vec,
  output logic               pending,
  output logic [VEC_W-1:0]   top_vec
);
  always_comb begin
    pending = 1'b0;
    top_vec = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (req_vec[i]) begin
        pending = 1'b1;
        top_vec = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/vt_regport.sv
module vt_regport
  import vt_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr_en,
  input  logic [NUM_VEC-1:0] req_vec,
  input  logic [NUM_VEC-1:0] isr_vec,
  input  logic [NUM_VEC-1:0] en_vec,
  input  logic [NUM_VEC-1:0] trig_vec,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               en_wr,
  output logic [WIDX_W-1:0]  en_wr_word,
  output logic               ro_write,
  output logic               reg_wr_err
);
  vt_region_e rgn;
  int         widx;

  always_comb begin
    rgn  = decode_region(reg_addr, NUM_WORDS);
    widx = 0;
    unique case (rgn)
      RGN_ISR:  widx = word_index(reg_addr, BASE_ISR);
      RGN_TRIG: widx = word_index(reg_addr, BASE_TRIG);
      RGN_REQ:  widx = word_index(reg_addr, BASE_REQ);
      RGN_EN:   widx = word_index(reg_addr, BASE_EN);
      default:  widx = 0;
    endcase
  end

  always_comb begin
    unique case (rgn)
      RGN_ISR:  reg_rdata = isr_vec[widx*WORD_W +: WORD_W];
      RGN_TRIG: reg_rdata = trig_vec[widx*WORD_W +: WORD_W];
      RGN_REQ:  reg_rdata = req_vec[widx*WORD_W +: WORD_W];
      RGN_EN:   reg_rdata = en_vec[widx*WORD_W +: WORD_W];
      default:  reg_rdata = '0;
    endcase
  end

  assign en_wr      = reg_wr_en && (rgn == RGN_EN);
  assign en_wr_word = WIDX_W'(widx);
  assign ro_write   = reg_wr_en && ((rgn == RGN_ISR) || (rgn == RGN_TRIG) || (rgn == RGN_REQ));

  always_ff @(posedge clk) begin
    if (!rst_n) reg_wr_err <= 1'b0;
    else        reg_wr_err <= ro_write;
  end
endmodule

// File: rtl/vec_tracker.sv
module vec_tracker #(
  parameter int NUM_VEC   = 256,
  parameter int WORD_W    = 32,
  parameter int MIN_LEGAL = 16,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int NUM_WORDS = NUM_VEC / WORD_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      raise_valid,
  input  logic [VEC_W-1:0]          raise_vec,
  input  logic                      lower_valid,
  input  logic [VEC_W-1:0]          lower_vec,
  input  logic                      ack_valid,
  input  logic [VEC_W-1:0]          ack_vec,
  input  logic [vt_pkg::ADDR_W-1:0] reg_addr,
  input  logic                      reg_wr_en,
  input  logic [WORD_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata,
  output logic                      reg_wr_err,
  output logic                      raise_err,
  output logic                      pending,
  output logic [VEC_W-1:0]          top_vec
);
  logic [NUM_VEC-1:0] req_vec, isr_vec, en_vec, trig_vec;
  logic               raise_accept, raise_illegal;
  logic               en_wr, ro_write;
  logic [WIDX_W-1:0]  en_wr_word;

  // Trigger mode is never set by any command in this block
  assign trig_vec = '0;

  vt_vec_bank #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .MIN_LEGAL(MIN_LEGAL)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_vec(raise_vec),
    .lower_valid(lower_valid), .lower_vec(lower_vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec),
    .en_wr(en_wr), .en_wr_word(en_wr_word), .en_wr_data(reg_wdata),
    .req_vec(req_vec), .isr_vec(isr_vec), .en_vec(en_vec),
    .raise_accept(raise_accept), .raise_illegal(raise_illegal),
    .raise_err(raise_err)
  );

  vt_prio_enc #(.NUM_VEC(NUM_VEC)) enc_i (
    .req_vec(req_vec), .pending(pending), .top_vec(top_vec)
  );

  vt_regport #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) port_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .req_vec(req_vec), .isr_vec(isr_vec), .en_vec(en_vec), .trig_vec(trig_vec),
    .reg_rdata(reg_rdata), .en_wr(en_wr), .en_wr_word(en_wr_word),
    .ro_write(ro_write), .reg_wr_err(reg_wr_err)
  );
endmodule

// File: rtl/vec_tracker_chk.sv
module vec_tracker_chk #(
  parameter int NUM_VEC   = 256,
  parameter int MIN_LEGAL = 16,
  localparam int VEC_W = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               raise_valid,
  input logic [VEC_W-1:0]   raise_vec,
  input logic               lower_valid,
  input logic               ack_valid,
  input logic [VEC_W-1:0]   ack_vec,
  input logic               reg_wr_en,
  input logic [11:0]        reg_addr,
  input logic               raise_err,
  input logic               reg_wr_err,
  input logic               pending,
  input logic [VEC_W-1:0]   top_vec,
  input logic [NUM_VEC-1:0] req_vec,
  input logic [NUM_VEC-1:0] isr_vec,
  input logic [NUM_VEC-1:0] en_vec
);
  logic ill_raise, ok_raise, ro_addr;
  assign ill_raise = raise_valid && (int'(raise_vec) < MIN_LEGAL);
  assign ok_raise  = raise_valid && !ill_raise && en_vec[raise_vec];
  assign ro_addr   = (reg_addr >= 12'h100) && (reg_addr < 12'h280) && (reg_addr[3:0] == 4'h0);

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ill_raise |=> raise_err); // R3

  AST_ILLEGAL_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_raise && !lower_valid && !ack_valid && !reg_wr_en) |=> $stable(req_vec) && $stable(isr_vec)); // R3

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ok_raise |=> req_vec[$past(raise_vec)]); // R8

  AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !(ok_raise && raise_vec == ack_vec)) |=> isr_vec[$past(ack_vec)] && !req_vec[$past(ack_vec)]); // R6

  AST_ISR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_vec & $past(isr_vec)) == $past(isr_vec))); // R6

  AST_TOP_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> req_vec[top_vec]); // R7

  AST_RO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && ro_addr) |=> reg_wr_err && $stable(en_vec)); // R11
endmodule

bind vec_tracker vec_tracker_chk #(.NUM_VEC(NUM_VEC), .MIN_LEGAL(MIN_LEGAL)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .raise_valid(raise_valid), .raise_vec(raise_vec),
  .lower_valid(lower_valid),
  .ack_valid(ack_valid), .ack_vec(ack_vec),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .raise_err(raise_err), .reg_wr_err(reg_wr_err),
  .pending(pending), .top_vec(top_vec),
  .req_vec(req_vec), .isr_vec(isr_vec), .en_vec(en_vec)
);

// File: tb/vec_tracker_tb.sv
module vec_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_valid = 1'b0, lower_valid = 1'b0, ack_valid = 1'b0;
  logic [7:0]  raise_vec = '0, lower_vec = '0, ack_vec = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_wr_err, raise_err, pending;
  logic [7:0]  top_vec;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // behavioural reference state
  bit [255:0] m_req, m_isr, m_en;
  bit         m_rerr, m_werr;

  always #2 clk = ~clk;

  vec_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_vec(raise_vec),
    .lower_valid(lower_valid), .lower_vec(lower_vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_wr_err(reg_wr_err), .raise_err(raise_err),
    .pending(pending), .top_vec(top_vec)
  );

  task automatic report_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      report_and_end();
    end
  end

  function automatic int exp_top();
    for (int i = 255; i >= 0; i--) if (m_req[i]) return i;
    return 0;
  endfunction

  function automatic bit [31:0] exp_word(input int a);
    int off;
    if (a % 16 != 0) return 32'h0;
    if (a >= 256 && a < 384)  begin off = (a - 256) / 16;  return m_isr[off*32 +: 32]; end
    if (a >= 384 && a < 512)  return 32'h0;
    if (a >= 512 && a < 640)  begin off = (a - 512) / 16;  return m_req[off*32 +: 32]; end
    if (a >= 1152 && a < 1280) begin off = (a - 1152) / 16; return m_en[off*32 +: 32]; end
    return 32'h0;
  endfunction

  task automatic model_step();
    bit ok;
    int a;
    a = int'(reg_addr);
    if (!rst_n) begin
      m_req = '0; m_isr = '0; m_en = '1; m_rerr = 0; m_werr = 0;
      return;
    end
    ok = raise_valid && raise_vec >= 16 && m_en[raise_vec];
    m_rerr = raise_valid && raise_vec < 16;
    m_werr = reg_wr_en && (a % 16 == 0) && a >= 256 && a < 640;
    if (lower_valid) m_req[lower_vec] = 0;
    if (ack_valid) begin m_isr[ack_vec] = 1; m_req[ack_vec] = 0; end
    if (ok) m_req[raise_vec] = 1;
    if (reg_wr_en && (a % 16 == 0) && a >= 1152 && a < 1280)
      m_en[((a - 1152) / 16) * 32 +: 32] = reg_wdata;
  endtask

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, "pending", pending, |m_req);
    cmp(tag, "top_vec", top_vec, exp_top());
    cmp(tag, "raise_err", raise_err, m_rerr);
    cmp(tag, "reg_wr_err", reg_wr_err, m_werr);
    cmp(tag, "reg_rdata", reg_rdata, exp_word(int'(reg_addr)));
  endtask

  // one clock: inputs already driven; model steps at the edge; outputs compared at the falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    raise_valid = 0; lower_valid = 0; ack_valid = 0; reg_wr_en = 0;
  endtask

  task automatic do_raise(input int v, input string tag);
    raise_valid = 1; raise_vec = 8'(v); cyc(tag);
  endtask

  task automatic do_read(input int a, input string tag);
    reg_addr = 12'(a); cyc(tag);
  endtask

  initial begin
    m_req = '0; m_isr = '0; m_en = '1;
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst_n = 1;
    // R1: reset contents across all regions
    do_read(12'h100, "R1"); do_read(12'h1F0, "R1"); do_read(12'h270, "R1");
    do_read(12'h480, "R1"); do_read(12'h4F0, "R1");

    // R2 / R7: legal raises, highest wins
    reg_addr = 12'h220;
    do_raise(8'h40, "R2");
    do_raise(8'h20, "R7");
    do_raise(8'hA5, "R7");
    cyc("R7"); // idle: outputs hold

    // R3: illegal raises
    do_raise(15, "R3"); do_raise(0, "R3");
    cyc("R3");

    // R4: disable word 5 (vectors 160..191), raise is dropped
    reg_addr = 12'h4D0; reg_wdata = 32'h0; reg_wr_en = 1; cyc("R10");
    do_raise(8'hB0, "R4");
    reg_addr = 12'h250; cyc("R4");

    // R10: re-enable in the same cycle as a raise: old enable decides
    reg_addr = 12'h4D0; reg_wdata = 32'hFFFF_FFFF; reg_wr_en = 1;
    raise_valid = 1; raise_vec = 8'hB2; cyc("R10");
    reg_addr = 12'h250; cyc("R10");
    do_raise(8'hB2, "R10");

    // R5: lower
    lower_valid = 1; lower_vec = 8'h40; reg_addr = 12'h220; cyc("R5");
    lower_valid = 1; lower_vec = 8'hB2; cyc("R5");

    // R6: acknowledge
    reg_addr = 12'h150; ack_valid = 1; ack_vec = 8'hA5; cyc("R6");
    reg_addr = 12'h250; cyc("R6");
    ack_valid = 1; ack_vec = 8'h77; reg_addr = 12'h130; cyc("R6");

    // R8: raise vs ack and raise vs lower on the same vector
    raise_valid = 1; raise_vec = 8'h30; ack_valid = 1; ack_vec = 8'h30; reg_addr = 12'h210; cyc("R8");
    reg_addr = 12'h110; cyc("R8");
    raise_valid = 1; raise_vec = 8'h31; lower_valid = 1; lower_vec = 8'h31; reg_addr = 12'h210; cyc("R8");

    // R11: writes to read-only words, and an unmapped write
    reg_addr = 12'h210; reg_wdata = 32'h0; reg_wr_en = 1; cyc("R11");
    cyc("R11");
    reg_addr = 12'h110; reg_wdata = 32'h0; reg_wr_en = 1; cyc("R11");
    reg_addr = 12'h1A0; reg_wdata = 32'hFFFF_FFFF; reg_wr_en = 1; cyc("R11");
    reg_addr = 12'h300; reg_wdata = 32'hFFFF_FFFF; reg_wr_en = 1; cyc("R11");

    // R9: sweep every word of every region plus holes
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++)
        do_read((r == 3 ? 12'h480 : 12'h100 + r * 12'h80) + k * 16, "R9");
    do_read(12'h104, "R9"); do_read(12'h300, "R9"); do_read(12'h0F0, "R9"); do_read(12'h500, "R9");

    // mixed traffic, every cycle compared
    for (int n = 0; n < 600; n++) begin
      raise_valid = $urandom_range(0, 1); raise_vec = 8'($urandom_range(0, 255));
      lower_valid = ($urandom_range(0, 3) == 0); lower_vec = 8'($urandom_range(0, 255));
      ack_valid = ($urandom_range(0, 3) == 0); ack_vec = 8'($urandom_range(0, 255));
      reg_wr_en = ($urandom_range(0, 7) == 0);
      reg_addr = 12'(($urandom_range(0, 1) ? 12'h480 : 12'h100) + $urandom_range(0, 47) * 16);
      reg_wdata = $urandom;
      cyc("R7");
    end
    report_and_end();
  end
endmodule